// File: doc/BRIEF.md
# PLL Bring-Up and Configuration Sequencer

This controller owns the control word and the loop-configuration word of an on-chip frequency-synthesis PLL. Software-side logic (or a boot engine) writes a requested feedback divider and output divider through a single-cycle write strobe; the block checks both values, stores the divider, and presents a configuration word whose loop-filter, charge-pump and lock-detector fields are looked up from the divider value.

An enable command runs an ordered power-up handshake: the PLL is first put in bypass, then its three reset lines are released together, then the lock indication is watched for a bounded number of cycles. Bypass is removed only once lock has been seen; if the wait runs out, bypass stays on and a timeout flag is raised. A disable command drives all three reset lines back on at once. The analog PLL is outside the block; only its lock indication (bit 0 of its status register) comes in.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, pll_ctrl has bits 2:0 = 3'b111 (reset, power-on-reset input, power reset all asserted), bit 3 (bypass) = 0, bits 14:8 = DEF_FBDIV (default 50), bits 18:16 = 1, all other bits 0; busy, done, lock_timeout, div_err, post_err and clash are 0.
- R2: A write accepted while idle, with wr_fbdiv in 25..125 and wr_postdiv = 1, loads wr_fbdiv into pll_ctrl bits 14:8 on the next cycle, leaves bits 3:0 untouched, and clears div_err, post_err and clash.
- R3: pll_cfg holds the loop resistor code in bits 3:0, the charge-pump code in bits 8:5, the value 3 in bits 12:10, the lock count in bits 22:13, the value 63 in bits 31:25, and zero elsewhere, all derived from the stored divider.
- R4: Resistor/charge-pump pairs by divider: 25-26 give 10/3, 27-30 give 6/4, 31-32 give 1/6, 33 gives 10/4, 34-38 give 6/5, 39-50 give 12/3, 51-82 give 2/3, 83-102 give 2/4, 103-106 give 2/5, 107-125 give 4/3.
- R5: Lock count is 1000 up to divider 37, then 975, 950, 925, 900, 875 for 38 to 42, 850 for 43-44, 825 for 45, 800 for 46, 775 for 47-48, 750 for 49-50, 725 for 51, 700 for 52-53, 675 for 54-55, 650 for 56-57, 625 for 58-60, and 600 from 61 upward.
- R6: A write with wr_fbdiv outside 25..125 is refused: pll_ctrl and pll_cfg keep their values and div_err is set on the next cycle.
- R7: A write with wr_postdiv other than 1 is refused: pll_ctrl and pll_cfg keep their values and post_err is set on the next cycle.
- R8: A write made while busy is ignored (pll_ctrl and pll_cfg unchanged) and clash is set on the next cycle.
- R9: On en_cmd while idle, the next cycle shows bypass = 1 with reset bits still 3'b111 and busy = 1; the cycle after that shows all three reset bits cleared together with bypass still 1. Reset bits only ever read 3'b000 or 3'b111.
- R10: Once pll_locked is seen during the wait, bypass is cleared on the next edge, done is set and busy falls; bypass never falls without lock seen the cycle before.
- R11: If pll_locked is not seen within LOCK_TIMEOUT wait cycles, lock_timeout is set, bypass stays 1, done stays 0 and busy falls, busy having been high for LOCK_TIMEOUT+1 cycles; lock_timeout clears on the next enable.
- R12: dis_cmd sets all three reset bits on the next cycle, clears done, aborts any sequence in progress and leaves bypass as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Divider write strobe |
| wr_fbdiv | input | 7 | Requested feedback divider |
| wr_postdiv | input | 3 | Requested output divider code (must be 1) |
| en_cmd | input | 1 | Start the power-up handshake |
| dis_cmd | input | 1 | Put the PLL back into reset |
| pll_locked | input | 1 | Lock indication, bit 0 of the PLL status register |
| pll_ctrl | output | 32 | PLL control word |
| pll_cfg | output | 32 | PLL loop configuration word |
| busy | output | 1 | Handshake in progress |
| done | output | 1 | PLL locked and out of bypass |
| lock_timeout | output | 1 | Lock not seen within the wait window |
| div_err | output | 1 | Last refused write had an illegal divider |
| post_err | output | 1 | Last refused write had an illegal output divider |
| clash | output | 1 | A write arrived while busy |

## Verification
On every cycle the assertions check the ordering rules of the handshake: the reset lines are released only under bypass and always move as a group, bypass is removed only right after lock, a timeout leaves bypass set, disable forces the reset group on, and refused or colliding writes leave the divider and configuration words alone. The lookup values of the configuration word, the exact cycle counts of the handshake and of the timeout window, and the clearing of the sticky flags can only be shown by the bench's directed scenarios, which compare against literal values taken from the requirements.

// File: rtl/pll_seq_pkg.sv
// Shared field positions, limits and types of the PLL bring-up sequencer.
// Assumes a 32-bit control word and a 32-bit configuration word.
package pll_seq_pkg;
    localparam int FB_W = 7;
    localparam int OD_W = 3;
    localparam int LC_W = 10;

    // control word bit positions
    localparam int CB_RST   = 0;
    localparam int CB_BYP   = 3;
    localparam int CB_FB_LO = 8;
    localparam int CB_OD_LO = 16;

    // configuration word bit positions
    localparam int GB_RES_LO = 0;
    localparam int GB_CP_LO  = 5;
    localparam int GB_CAP_LO = 10;
    localparam int GB_LC_LO  = 13;
    localparam int GB_WIN_LO = 25;

    localparam logic [FB_W-1:0] FB_MIN      = 7'd25;
    localparam logic [FB_W-1:0] FB_MAX      = 7'd125;
    localparam logic [OD_W-1:0] OD_REQUIRED = 3'd1;
    localparam logic [2:0]      CAP_CODE    = 3'd3;
    localparam logic [6:0]      WIN_CODE    = 7'd63;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_RELEASE = 2'd1,
        SQ_WAIT    = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [3:0]      res;
        logic [3:0]      cp;
        logic [LC_W-1:0] lc;
    } loop_set_t;

    // true when a divider request lies in the legal window
    function automatic logic fb_legal(input logic [FB_W-1:0] d);
        return (d >= FB_MIN) && (d <= FB_MAX);
    endfunction
endpackage

// File: rtl/pll_loop_table.sv
// Maps a stored feedback divider to the packed loop configuration word.
// Assumes the divider is already within the legal window; purely combinational.
module pll_loop_table
    import pll_seq_pkg::*;
(
    input  logic [FB_W-1:0] fbdiv,
    output logic [31:0]     cfg_word
);
    loop_set_t ls;

    // resistor / charge-pump band selection
    always_comb begin
        if      (fbdiv <= 7'd26)  begin ls.res = 4'd10; ls.cp = 4'd3; end
        else if (fbdiv <= 7'd30)  begin ls.res = 4'd6;  ls.cp = 4'd4; end
        else if (fbdiv <= 7'd32)  begin ls.res = 4'd1;  ls.cp = 4'd6; end
        else if (fbdiv == 7'd33)  begin ls.res = 4'd10; ls.cp = 4'd4; end
        else if (fbdiv <= 7'd38)  begin ls.res = 4'd6;  ls.cp = 4'd5; end
        else if (fbdiv <= 7'd50)  begin ls.res = 4'd12; ls.cp = 4'd3; end
        else if (fbdiv <= 7'd82)  begin ls.res = 4'd2;  ls.cp = 4'd3; end
        else if (fbdiv <= 7'd102) begin ls.res = 4'd2;  ls.cp = 4'd4; end
        else if (fbdiv <= 7'd106) begin ls.res = 4'd2;  ls.cp = 4'd5; end
        else                      begin ls.res = 4'd4;  ls.cp = 4'd3; end
    end

    // lock-count schedule, falling with the divider
    always_comb begin
        if      (fbdiv <= 7'd37) ls.lc = 10'd1000;
        else if (fbdiv <= 7'd42) ls.lc = 10'(11'd1000 - 11'd25 * 11'(fbdiv - 7'd37));
        else if (fbdiv <= 7'd44) ls.lc = 10'd850;
        else if (fbdiv == 7'd45) ls.lc = 10'd825;
        else if (fbdiv == 7'd46) ls.lc = 10'd800;
        else if (fbdiv <= 7'd48) ls.lc = 10'd775;
        else if (fbdiv <= 7'd50) ls.lc = 10'd750;
        else if (fbdiv == 7'd51) ls.lc = 10'd725;
        else if (fbdiv <= 7'd53) ls.lc = 10'd700;
        else if (fbdiv <= 7'd55) ls.lc = 10'd675;
        else if (fbdiv <= 7'd57) ls.lc = 10'd650;
        else if (fbdiv <= 7'd60) ls.lc = 10'd625;
        else                     ls.lc = 10'd600;
    end

    // pack fields into their positions
    always_comb begin
        cfg_word = '0;
        cfg_word[GB_RES_LO +: 4]    = ls.res;
        cfg_word[GB_CP_LO  +: 4]    = ls.cp;
        cfg_word[GB_CAP_LO +: 3]    = CAP_CODE;
        cfg_word[GB_LC_LO  +: LC_W] = ls.lc;
        cfg_word[GB_WIN_LO +: 7]    = WIN_CODE;
    end
endmodule

// File: rtl/pll_lock_timer.sv
// Counts wait cycles and flags the last one of a LIMIT-cycle window.
// Assumes clr holds the count at zero whenever no wait is in progress.
module pll_lock_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // wait-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (run && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    assert_timer_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/pll_bringup_seq.sv
// PLL bring-up sequencer: validates divider writes, holds the control word,
// runs bypass -> release -> bounded lock wait -> leave bypass, and disable.
// Assumes pll_locked is synchronous to clk and reset is synchronous active-low.
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int LOCK_TIMEOUT = 100000,
    parameter int DEF_FBDIV    = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [FB_W-1:0] wr_fbdiv,
    input  logic [OD_W-1:0] wr_postdiv,
    input  logic            en_cmd,
    input  logic            dis_cmd,
    input  logic            pll_locked,
    output logic [31:0]     pll_ctrl,
    output logic [31:0]     pll_cfg,
    output logic            busy,
    output logic            done,
    output logic            lock_timeout,
    output logic            div_err,
    output logic            post_err,
    output logic            clash
);
    localparam logic [FB_W-1:0] FB_RESET = FB_W'(DEF_FBDIV);

    seq_state_t      state;
    logic [2:0]      rst_grp;
    logic            byp;
    logic [FB_W-1:0] fbdiv_q;
    logic [OD_W-1:0] od_q;
    logic            expired;

    assign busy = (state != SQ_IDLE);

    // lock-wait window counter
    pll_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != SQ_WAIT),
        .run     ((state == SQ_WAIT) && !pll_locked),
        .expired (expired)
    );

    // configuration lookup from the stored divider
    pll_loop_table u_table (
        .fbdiv    (fbdiv_q),
        .cfg_word (pll_cfg)
    );

    // handshake state machine; disable takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            rst_grp      <= 3'b111;
            byp          <= 1'b0;
            done         <= 1'b0;
            lock_timeout <= 1'b0;
        end else if (dis_cmd) begin
            state   <= SQ_IDLE;
            rst_grp <= 3'b111;
            done    <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: if (en_cmd) begin
                    byp          <= 1'b1;
                    done         <= 1'b0;
                    lock_timeout <= 1'b0;
                    state        <= SQ_RELEASE;
                end
                SQ_RELEASE: begin
                    rst_grp <= 3'b000;
                    state   <= SQ_WAIT;
                end
                SQ_WAIT: if (pll_locked) begin
                    byp   <= 1'b0;
                    done  <= 1'b1;
                    state <= SQ_IDLE;
                end else if (expired) begin
                    lock_timeout <= 1'b1;
                    state        <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // divider write path with refusal flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbdiv_q  <= FB_RESET;
            od_q     <= OD_REQUIRED;
            div_err  <= 1'b0;
            post_err <= 1'b0;
            clash    <= 1'b0;
        end else if (wr_en) begin
            if (busy)                         clash    <= 1'b1;
            else if (!fb_legal(wr_fbdiv))     div_err  <= 1'b1;
            else if (wr_postdiv != OD_REQUIRED) post_err <= 1'b1;
            else begin
                fbdiv_q  <= wr_fbdiv;
                od_q     <= wr_postdiv;
                div_err  <= 1'b0;
                post_err <= 1'b0;
                clash    <= 1'b0;
            end
        end
    end

    // control word assembly
    always_comb begin
        pll_ctrl = '0;
        pll_ctrl[CB_RST +: 3]      = rst_grp;
        pll_ctrl[CB_BYP]           = byp;
        pll_ctrl[CB_FB_LO +: FB_W] = fbdiv_q;
        pll_ctrl[CB_OD_LO +: OD_W] = od_q;
    end

    assert_release_under_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_ctrl[CB_RST]) |-> pll_ctrl[CB_BYP]);
    assert_reset_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_ctrl[2:0] == 3'b000) || (pll_ctrl[2:0] == 3'b111));
    assert_bypass_exit_on_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_ctrl[CB_BYP]) |-> $past(pll_locked));
    assert_timeout_keeps_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_timeout) |-> (pll_ctrl[CB_BYP] && !done));
    assert_disable_resets_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> ((pll_ctrl[2:0] == 3'b111) && !done && !busy));
    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> (clash && $stable(pll_cfg) && $stable(pll_ctrl[14:8])));
    assert_bad_div_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !fb_legal(wr_fbdiv)) |=> (div_err && $stable(pll_ctrl[14:8])));
    assert_bad_post_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && fb_legal(wr_fbdiv) && wr_postdiv != OD_REQUIRED)
        |=> (post_err && $stable(pll_ctrl[18:16]) && $stable(pll_ctrl[14:8])));
endmodule

// File: tb/sim_pll_bringup_seq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, a simple PLL lock model, own counters.
module sim_pll_bringup_seq;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_fbdiv = 7'd0;
    logic [2:0]  wr_postdiv = 3'd1;
    logic        en_cmd = 1'b0;
    logic        dis_cmd = 1'b0;
    logic        pll_locked;
    logic [31:0] pll_ctrl, pll_cfg;
    logic        busy, done, lock_timeout, div_err, post_err, clash;

    int total = 0;
    int bad = 0;
    int lock_dly = 8;
    int lock_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pll_bringup_seq #(.LOCK_TIMEOUT(TMO), .DEF_FBDIV(50)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fbdiv(wr_fbdiv),
        .wr_postdiv(wr_postdiv), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .pll_locked(pll_locked), .pll_ctrl(pll_ctrl), .pll_cfg(pll_cfg),
        .busy(busy), .done(done), .lock_timeout(lock_timeout),
        .div_err(div_err), .post_err(post_err), .clash(clash)
    );

    // analog PLL stand-in: locks lock_dly cycles after all resets drop
    always_ff @(posedge clk) begin
        if (pll_ctrl[2:0] != 3'b000) lock_cnt <= 0;
        else if (lock_cnt < lock_dly) lock_cnt <= lock_cnt + 1;
    end
    assign pll_locked = (pll_ctrl[2:0] == 3'b000) && (lock_cnt >= lock_dly);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_of(input int res, input int cp, input int lc);
        return 32'(res) | (32'(cp) << 5) | (32'd3 << 10) | (32'(lc) << 13) | (32'd63 << 25);
    endfunction

    task automatic do_write(input logic [6:0] d, input logic [2:0] p);
        @(negedge clk); wr_en = 1'b1; wr_fbdiv = d; wr_postdiv = p;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_disable();
        @(negedge clk); dis_cmd = 1'b1;
        @(negedge clk); dis_cmd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] e;
        e = (32'd1 << 16) | (32'd50 << 8) | 32'd7;
        chk(pll_ctrl == e, "R1 ctrl", pll_ctrl, e);
        chk(pll_cfg == cfg_of(12, 3, 750), "R1 cfg", pll_cfg, cfg_of(12, 3, 750));
        chk({busy, done, lock_timeout, div_err, post_err, clash} == 6'b0, "R1 flags",
            32'({busy, done, lock_timeout, div_err, post_err, clash}), 32'd0);
    endtask

    task automatic t_point(input logic [6:0] d, input int res, input int cp, input int lc);
        do_write(d, 3'd1);
        chk(pll_ctrl[14:8] == d, "R2 fbdiv field", 32'(pll_ctrl[14:8]), 32'(d));
        chk(pll_ctrl[3:0] == 4'b0111, "R2 low bits untouched", 32'(pll_ctrl[3:0]), 32'd7);
        chk(pll_cfg == cfg_of(res, cp, lc), "R3 R4 R5 cfg", pll_cfg, cfg_of(res, cp, lc));
    endtask

    task automatic t_bad_div();
        logic [31:0] c0, g0;
        c0 = pll_ctrl; g0 = pll_cfg;
        do_write(7'd24, 3'd1);
        chk(div_err, "R6 div_err low", 32'(div_err), 32'd1);
        chk(pll_ctrl == c0 && pll_cfg == g0, "R6 unchanged 24", pll_ctrl, c0);
        do_write(7'd126, 3'd1);
        chk(pll_ctrl == c0 && pll_cfg == g0, "R6 unchanged 126", pll_ctrl, c0);
        do_write(7'd70, 3'd1);
        chk(!div_err && pll_ctrl[14:8] == 7'd70, "R2 error cleared", 32'(div_err), 32'd0);
    endtask

    task automatic t_bad_post();
        logic [31:0] c0, g0;
        c0 = pll_ctrl; g0 = pll_cfg;
        do_write(7'd40, 3'd2);
        chk(post_err, "R7 post_err", 32'(post_err), 32'd1);
        chk(pll_ctrl == c0 && pll_cfg == g0, "R7 unchanged", pll_ctrl, c0);
    endtask

    task automatic t_enable_lock();
        int n;
        lock_dly = 8;
        @(negedge clk); en_cmd = 1'b1;
        @(negedge clk); en_cmd = 1'b0;
        chk(pll_ctrl[3:0] == 4'b1111 && busy, "R9 bypass first", 32'(pll_ctrl[3:0]), 32'hF);
        @(negedge clk);
        chk(pll_ctrl[3:0] == 4'b1000, "R9 resets released", 32'(pll_ctrl[3:0]), 32'h8);
        n = 0;
        while (busy && n < 200) begin @(negedge clk); n++; end
        chk(done && !pll_ctrl[3] && !lock_timeout, "R10 locked and out of bypass",
            32'({done, pll_ctrl[3], lock_timeout}), 32'b100);
    endtask

    task automatic t_disable();
        do_disable();
        chk(pll_ctrl[3:0] == 4'b0111 && !done, "R12 resets on, done off",
            32'({done, pll_ctrl[3:0]}), 32'h07);
    endtask

    task automatic t_timeout();
        int n;
        lock_dly = 1000;
        @(negedge clk); en_cmd = 1'b1;
        @(negedge clk); en_cmd = 1'b0;
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(n == TMO + 1, "R11 window length", 32'(n), 32'(TMO + 1));
        chk(lock_timeout && pll_ctrl[3] && !done, "R11 bypass kept",
            32'({lock_timeout, pll_ctrl[3], done}), 32'b110);
        do_disable();
    endtask

    task automatic t_clash();
        logic [31:0] c0, g0;
        @(negedge clk); en_cmd = 1'b1;
        @(negedge clk); en_cmd = 1'b0;
        chk(!lock_timeout, "R11 cleared on enable", 32'(lock_timeout), 32'd0);
        repeat (3) @(negedge clk);
        c0 = pll_ctrl; g0 = pll_cfg;
        do_write(7'd30, 3'd1);
        chk(clash, "R8 clash flag", 32'(clash), 32'd1);
        chk(pll_ctrl[14:8] == c0[14:8] && pll_cfg == g0, "R8 write ignored",
            32'(pll_ctrl[14:8]), 32'(c0[14:8]));
        do_disable();
        chk(!busy && pll_ctrl[3] && pll_ctrl[2:0] == 3'b111, "R12 abort keeps bypass",
            32'({busy, pll_ctrl[3:0]}), 32'h0F);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_point(7'd25, 10, 3, 1000);
        t_point(7'd31, 1, 6, 1000);
        t_point(7'd33, 10, 4, 1000);
        t_point(7'd38, 6, 5, 975);
        t_point(7'd44, 12, 3, 850);
        t_point(7'd60, 2, 3, 625);
        t_point(7'd61, 2, 3, 600);
        t_point(7'd100, 2, 4, 600);
        t_point(7'd105, 2, 5, 600);
        t_point(7'd125, 4, 3, 600);
        t_bad_div();
        t_bad_post();
        t_enable_lock();
        t_disable();
        t_timeout();
        t_clash();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule